// File: doc/BRIEF.md
# Coherent Converter Result Read Port

This block sits between a 10-bit analog-to-digital converter and an 8-bit CPU peripheral bus. It lets firmware read a wide conversion result in two byte-sized reads without tearing. Each single-cycle conversion-done strobe loads the accompanying 10-bit value into a holding register. The bus can then read two addresses. The first returns the upper eight bits of the result. The second returns the two least-significant bits, left-aligned.

The low bits are not read live. Any read of the high address copies the current two low bits into a shadow register. Reads of the low address return that shadow. Firmware reads the high byte first and the low bits second. The pair then always describes one conversion, even if a new result lands between the two accesses.

Read data is registered. A small response state machine records what kind of access was seen on each edge: idle, high byte, low bits or miss. It also captures the matching data, which an output process then drives onto the bus. The states are S_IDLE, S_HI_DATA, S_LO_DATA and S_MISS. Every edge makes one transition, chosen by that cycle's access:
- A read of 0xF72 goes to S_HI_DATA.
- A read of 0xF73 goes to S_LO_DATA.
- A read of any other address goes to S_MISS.
- A write, or no access, goes to S_IDLE.

Top module: `adc_result_regs`

## Requirements
- R1: On a clock edge with `conv_done` high, the holding register loads `conv_data`. Without the strobe it keeps its value, however many cycles pass.
- R2: A read of address 0xF72 returns holding-register bits [9:2] on `bus_rdata[7:0]` in the cycle after the read strobe.
- R3: A read of address 0xF73 returns the shadow low bits on `bus_rdata[7:6]` in the cycle after the strobe. Bits [5:0] read as zero.
- R4: Every read of 0xF72 copies holding-register bits [1:0] into the shadow. Nothing else changes the shadow, so repeated reads of 0xF73 return the same value.
- R5: A high read, then a conversion, then a low read returns low bits from the result the high read saw, not from the new one.
- R6: When `conv_done` and a high read share a cycle, the read returns the old upper bits and latches the old low bits. A high read in the next cycle returns the new value.
- R7: Asserting `bus_wr` to 0xF72 or 0xF73 changes neither the holding register nor the shadow.
- R8: A read of any address other than 0xF72/0xF73 returns 0x00. In a cycle after no read, `bus_rdata` is 0x00.
- R9: After reset, `bus_rdata` is 0x00. The result and shadow contents carry no meaning until the first conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_done | input | 1 | Single-cycle conversion-complete strobe |
| conv_data | input | 10 | Converter result, valid with `conv_done` |
| bus_addr | input | 12 | Peripheral bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (has no effect on the registers) |
| bus_rdata | output | 8 | Registered read data, valid one cycle after `bus_rd` |

## Verification
The bench sweeps all 1024 result codes through a high read and a low read. This catches a swapped or misaligned bit slice, and reserved bits that leak non-zero data.

It places a second conversion between the two reads of a pair. A design that reads the low bits live would then return the newer code's low bits.

It lands the strobe in the same cycle as a high read. A design that forwards the new value, or latches the new low bits, would give a mismatched pair.

Writes to both addresses, runs of conversions with no reads, and reads of neighbouring addresses expose holding logic that accepts bus writes, loses the last code, or decodes too few address bits.

// File: rtl/adc_rr_pkg.sv
package adc_rr_pkg;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_WRITE,
        ACC_HI,
        ACC_LO,
        ACC_MISS
    } acc_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_HI_DATA,
        S_LO_DATA,
        S_MISS
    } rsp_state_t;

endpackage

// File: rtl/adc_rr_decode.sv
module adc_rr_decode
    import adc_rr_pkg::*;
#(
    parameter int          ADDR_W  = 12,
    parameter logic [11:0] HI_ADDR = 12'hF72,
    parameter logic [11:0] LO_ADDR = 12'hF73
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output acc_t              kind
);

    always_comb begin
        if (rd) begin
            if (addr == HI_ADDR[ADDR_W-1:0])      kind = ACC_HI;
            else if (addr == LO_ADDR[ADDR_W-1:0]) kind = ACC_LO;
            else                                  kind = ACC_MISS;
        end else if (wr) begin
            kind = ACC_WRITE;
        end else begin
            kind = ACC_NONE;
        end
    end

endmodule

// File: rtl/adc_rr_hold.sv
module adc_rr_hold #(
    parameter int RES_W = 10,
    parameter int LOW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RES_W-1:0] din,
    input  logic             snap,
    output logic [RES_W-1:0] result_q,
    output logic [LOW_W-1:0] shadow_q
);

    // Result and shadow are cleared only for determinism; firmware must not rely on them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            shadow_q <= '0;
        end else begin
            if (snap) shadow_q <= result_q[LOW_W-1:0];
            if (load) result_q <= din;
        end
    end

endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
    import adc_rr_pkg::*;
#(
    parameter int          RES_W   = 10,
    parameter int          DATA_W  = 8,
    parameter int          ADDR_W  = 12,
    parameter logic [11:0] HI_ADDR = 12'hF72,
    parameter logic [11:0] LO_ADDR = 12'hF73
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_data,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int LOW_W = RES_W - DATA_W;

    acc_t              kind;
    rsp_state_t        state_q, state_d;
    logic [RES_W-1:0]  result_w;
    logic [LOW_W-1:0]  shadow_w;
    logic [DATA_W-1:0] hi_cap_q;
    logic [LOW_W-1:0]  lo_cap_q;

    adc_rr_decode #(
        .ADDR_W (ADDR_W),
        .HI_ADDR(HI_ADDR),
        .LO_ADDR(LO_ADDR)
    ) u_dec (
        .addr(bus_addr),
        .rd  (bus_rd),
        .wr  (bus_wr),
        .kind(kind)
    );

    adc_rr_hold #(
        .RES_W(RES_W),
        .LOW_W(LOW_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (conv_done),
        .din     (conv_data),
        .snap    (kind == ACC_HI),
        .result_q(result_w),
        .shadow_q(shadow_w)
    );

    // Next response state from this cycle's access.
    always_comb begin
        unique case (kind)
            ACC_HI:   state_d = S_HI_DATA;
            ACC_LO:   state_d = S_LO_DATA;
            ACC_MISS: state_d = S_MISS;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register, with the data captured at the access edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            hi_cap_q <= '0;
            lo_cap_q <= '0;
        end else begin
            state_q  <= state_d;
            hi_cap_q <= result_w[RES_W-1:LOW_W];
            lo_cap_q <= shadow_w;
        end
    end

    // Output mux: reserved low-register bits and non-data states read zero.
    always_comb begin
        unique case (state_q)
            S_HI_DATA: bus_rdata = hi_cap_q;
            S_LO_DATA: bus_rdata = {lo_cap_q, {(DATA_W-LOW_W){1'b0}}};
            S_MISS:    bus_rdata = '0;
            S_IDLE:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/adc_result_regs_chk.sv
module adc_result_regs_chk #(
    parameter int          RES_W   = 10,
    parameter int          DATA_W  = 8,
    parameter int          ADDR_W  = 12,
    parameter logic [11:0] HI_ADDR = 12'hF72,
    parameter logic [11:0] LO_ADDR = 12'hF73
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      conv_done,
    input logic [RES_W-1:0]          conv_data,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic                      bus_rd,
    input logic                      bus_wr,
    input logic [DATA_W-1:0]         bus_rdata,
    input logic [RES_W-1:0]          result,
    input logic [RES_W-DATA_W-1:0]   shadow
);

    localparam int LOW_W = RES_W - DATA_W;

    logic is_hi, is_lo;
    assign is_hi = bus_rd && (bus_addr == HI_ADDR[ADDR_W-1:0]);
    assign is_lo = bus_rd && (bus_addr == LO_ADDR[ADDR_W-1:0]);

    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> result == $past(conv_data));

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(result));

    p_hi_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_hi |=> bus_rdata == $past(result[RES_W-1:LOW_W]));

    p_lo_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_lo |=> bus_rdata[DATA_W-LOW_W-1:0] == '0);

    p_snap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_hi |=> shadow == $past(result[LOW_W-1:0]));

    p_shadow_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !is_hi |=> $stable(shadow));

    p_wr_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !conv_done) |=> $stable(result));

    p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !is_hi && !is_lo) |=> bus_rdata == '0);

    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == '0);

endmodule

bind adc_result_regs adc_result_regs_chk #(
    .RES_W  (RES_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .HI_ADDR(HI_ADDR),
    .LO_ADDR(LO_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .conv_done(conv_done),
    .conv_data(conv_data),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_rdata(bus_rdata),
    .result   (result_w),
    .shadow   (shadow_w)
);

// File: tb/adc_result_regs_test.sv
module adc_result_regs_test;

    localparam logic [11:0] HI = 12'hF72;
    localparam logic [11:0] LO = 12'hF73;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 1'b0;
    logic [9:0]  conv_data = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    adc_result_regs uut (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] hi_of(input logic [9:0] v);
        return v[9:2];
    endfunction

    function automatic logic [7:0] lo_of(input logic [9:0] v);
        return {v[1:0], 6'b0};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic convert(input logic [9:0] v);
        conv_done = 1'b1;
        conv_data = v;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        bus_addr = a;
        bus_rd = 1'b1;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a);
        bus_addr = a;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got hung expected done");
            summary();
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        chk("R9 reset rdata", bus_rdata, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle after reset", bus_rdata, 8'h00);

        // R2/R3 sweep over every result code
        for (int v = 0; v < 1024; v++) begin
            convert(10'(v));
            rd(HI, d);
            chk("R2 high byte", d, hi_of(10'(v)));
            rd(LO, d);
            chk("R3 low bits", d, lo_of(10'(v)));
        end
        @(negedge clk);
        chk("R8 idle after read", bus_rdata, 8'h00);

        // R4 repeated low reads stay put
        convert(10'h2C1);
        rd(HI, d);
        convert(10'h102);
        for (int i = 0; i < 3; i++) begin
            rd(LO, d);
            chk("R4 shadow held", d, lo_of(10'h2C1));
        end

        // R5 conversion between high and low reads
        for (int k = 0; k < 16; k++) begin
            logic [9:0] a, b;
            a = 10'(k * 67 + 5);
            b = 10'(k * 131 + 2);
            convert(a);
            rd(HI, d);
            chk("R5 high of first", d, hi_of(a));
            convert(b);
            rd(LO, d);
            chk("R5 low of first", d, lo_of(a));
            rd(HI, d);
            chk("R5 high of second", d, hi_of(b));
            rd(LO, d);
            chk("R5 low of second", d, lo_of(b));
        end

        // R1 back-to-back conversions, no reads, then a long hold
        for (int k = 0; k < 8; k++) convert(10'(k * 97 + 11));
        repeat (20) @(negedge clk);
        rd(HI, d);
        chk("R1 last of burst high", d, hi_of(10'(7 * 97 + 11)));
        rd(LO, d);
        chk("R1 last of burst low", d, lo_of(10'(7 * 97 + 11)));

        // R6 strobe in same cycle as high read
        convert(10'h155);
        conv_done = 1'b1;
        conv_data = 10'h2AA;
        bus_addr = HI;
        bus_rd = 1'b1;
        @(negedge clk);
        d = bus_rdata;
        conv_done = 1'b0;
        bus_rd = 1'b0;
        chk("R6 same-cycle high old", d, hi_of(10'h155));
        rd(LO, d);
        chk("R6 same-cycle low old", d, lo_of(10'h155));
        rd(HI, d);
        chk("R6 next high new", d, hi_of(10'h2AA));
        rd(LO, d);
        chk("R6 next low new", d, lo_of(10'h2AA));

        // R7 writes to both addresses ignored
        convert(10'h3C6);
        rd(HI, d);
        wr(HI);
        wr(LO);
        chk("R7 write cycle rdata", bus_rdata, 8'h00);
        rd(LO, d);
        chk("R7 shadow after writes", d, lo_of(10'h3C6));
        wr(HI);
        wr(LO);
        rd(HI, d);
        chk("R7 high after writes", d, hi_of(10'h3C6));
        rd(LO, d);
        chk("R7 low after writes", d, lo_of(10'h3C6));

        // R8 reads of other addresses
        for (int k = 0; k < 16; k++) begin
            logic [11:0] a;
            a = (k < 8) ? 12'(12'hF70 + k) : 12'(12'h072 + (k << 8));
            if (a != HI && a != LO) begin
                rd(a, d);
                chk("R8 miss address", d, 8'h00);
            end
        end

        finished = 1'b1;
        summary();
    end

endmodule